// File: doc/BRIEF.md
# Bipartite Montgomery Modular Multiplier

This block multiplies two residues A and B modulo an odd modulus m and returns A·B·2^-(N/2) mod m, the Montgomery product with R = 2^(N/2). It splits B into an upper half Bh and a lower half Bl, so that B = Bh·R + Bl. The product then becomes the sum of two independent terms: A·Bh mod m, which is a plain modular multiply, and A·Bl·R^-1 mod m, which is a Montgomery multiply. Each term needs only N/2 bit steps. Two lanes compute the terms side by side, one bit per clock each, and a final stage adds them modulo m.

A caller waits for `ready`, then drives `op_a`, `op_b` and `modulus` and pulses `start`. The block captures the operands on that edge and works for N/2 + 2 cycles. It then raises `done` for one cycle and presents the result on `product`. The result stays on `product` until the next result replaces it.

The control is a four-state machine:
- **IDLE** waits for work. Transition *accept* (`start` while IDLE) loads both lanes and goes to **RUN**.
- **RUN** steps both lanes once per cycle. Transition *last_bit* (after N/2 steps) goes to **TRIM**.
- **TRIM** brings the Montgomery lane from [0, 2m) down into [0, m) with one conditional subtraction. Transition *trimmed* goes to **MERGE**.
- **MERGE** registers the modular sum and pulses `done`. Transition *finish* returns to **IDLE**.

Top module: `bipartite_modmul`

## Requirements
- R1: When done is high, `product` equals A·B·2^-(N/2) mod m for the A, B, m captured at the accepted start, given A < m, B < m and m odd. The result is always below m.
- R2: `ready` is 1 in IDLE. It is 0 from the cycle after an accepted start until `done` rises, and it is 1 again in the cycle where `done` is high.
- R3: `done` is a single-cycle pulse. It rises N/2 + 2 clock edges after the edge that accepts `start`.
- R4: A `start` that arrives while the block is busy is ignored. No second operation begins and no extra `done` pulse appears.
- R5: Changes on `op_a`, `op_b` or `modulus` after the accepting edge do not affect the result of the operation in progress.
- R6: After reset, `ready` = 1, `done` = 0 and `product` = 0.
- R7: The internal partial results stay bounded at every step: the plain lane stays below m and the Montgomery lane stays below 2m. As a result, m up to 2^N − 1 gives correct results with no overflow.
- R8: A zero operand (A = 0 or B = 0) gives `product` = 0. The edge values A = 1 and A = B = m − 1 give the exact modular result.
- R9: `product` holds its last value while the block is idle or busy, and changes only at a MERGE edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; taken only while ready |
| op_a | input | N | Multiplicand A, below modulus |
| op_b | input | N | Multiplier B, below modulus |
| modulus | input | N | Odd modulus m |
| ready | output | 1 | High when a start will be accepted |
| done | output | 1 | One-cycle pulse marking a new result |
| product | output | N | A·B·2^-(N/2) mod m, held between results |

## Verification
A wrong internal state in either lane always ends up at the ports: it shows as a wrong `product` in the `done` cycle exactly N/2 + 2 edges after the accepting edge. The bench therefore compares every result against an independent big-integer model.

A state machine that stalls or skips states shows within the same window, because `done` arrives late or early, or `ready` stays high while the block is busy. A `start` that is wrongly accepted while busy shows as an extra `done` pulse, or as a result computed from the disturbing operands instead of the captured ones.

The checker watches the lane bounds on every RUN cycle, so an overflow is flagged in the cycle it happens, before it reaches `product`.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_TRIM  = 2'd2,
        S_MERGE = 2'd3
    } state_t;
endpackage

// File: rtl/bpm_plain_lane.sv
// Interleaved modular multiply of A by the upper half of B, MSB first.
module bpm_plain_lane #(
    parameter int N = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [N-1:0]     a,
    input  logic [N-1:0]     m,
    input  logic [N/2-1:0]   bits,
    output logic [N+1:0]     acc
);
    localparam int H = N / 2;
    localparam int W = N + 2;

    logic [H-1:0] bits_q;
    logic [W-1:0] acc_q;
    logic [W-1:0] m1, m2, dbl, nxt;

    always_comb begin
        m1  = {2'b00, m};
        m2  = m1 << 1;
        dbl = (acc_q << 1) + (bits_q[H-1] ? {2'b00, a} : '0);
        if (dbl >= m2)
            nxt = dbl - m2;
        else if (dbl >= m1)
            nxt = dbl - m1;
        else
            nxt = dbl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            bits_q <= '0;
        end else if (load) begin
            acc_q  <= '0;
            bits_q <= bits;
        end else if (step) begin
            acc_q  <= nxt;
            bits_q <= bits_q << 1;
        end
    end

    assign acc = acc_q;
endmodule

// File: rtl/bpm_mont_lane.sv
// Radix-2 Montgomery multiply of A by the lower half of B, LSB first.
module bpm_mont_lane #(
    parameter int N = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             trim,
    input  logic [N-1:0]     a,
    input  logic [N-1:0]     m,
    input  logic [N/2-1:0]   bits,
    output logic [N+1:0]     acc
);
    localparam int H = N / 2;
    localparam int W = N + 2;

    logic [H-1:0] bits_q;
    logic [W-1:0] acc_q;
    logic [W-1:0] m1, sum, odd_fix, nxt, trimmed;

    always_comb begin
        m1      = {2'b00, m};
        sum     = acc_q + (bits_q[0] ? {2'b00, a} : '0);
        odd_fix = sum + (sum[0] ? m1 : '0);
        nxt     = odd_fix >> 1;
        trimmed = (acc_q >= m1) ? (acc_q - m1) : acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            bits_q <= '0;
        end else if (load) begin
            acc_q  <= '0;
            bits_q <= bits;
        end else if (step) begin
            acc_q  <= nxt;
            bits_q <= bits_q >> 1;
        end else if (trim) begin
            acc_q  <= trimmed;
        end
    end

    assign acc = acc_q;
endmodule

// File: rtl/bpm_mod_add.sv
// Adds two residues below m and reduces the sum once.
module bpm_mod_add #(
    parameter int N = 64
) (
    input  logic [N+1:0] x,
    input  logic [N+1:0] y,
    input  logic [N-1:0] m,
    output logic [N+1:0] z
);
    logic [N+1:0] m1, s;

    always_comb begin
        m1 = {2'b00, m};
        s  = x + y;
        z  = (s >= m1) ? (s - m1) : s;
    end
endmodule

// File: rtl/bipartite_modmul.sv
module bipartite_modmul #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic [N-1:0] modulus,
    output logic         ready,
    output logic         done,
    output logic [N-1:0] product
);
    import bpm_pkg::*;

    localparam int H  = N / 2;
    localparam int W  = N + 2;
    localparam int CW = (H > 1) ? $clog2(H) : 1;

    state_t        state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [N-1:0]  a_q, m_q;
    logic          accept, lane_step, lane_trim;
    logic [W-1:0]  plain_acc, mont_acc, merged;
    logic          done_q;
    logic [N-1:0]  product_q;
    logic          unused_merge_hi;

    assign accept    = (state_q == S_IDLE) && start;
    assign lane_step = (state_q == S_RUN);
    assign lane_trim = (state_q == S_TRIM);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_RUN;
            S_RUN:   if (cnt_q == CW'(H - 1)) state_d = S_TRIM;
            S_TRIM:  state_d = S_MERGE;
            S_MERGE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register, step counter and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            a_q     <= '0;
            m_q     <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q <= '0;
                a_q   <= op_a;
                m_q   <= modulus;
            end else if (lane_step) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    bpm_plain_lane #(.N(N)) u_plain (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (lane_step),
        .a     (a_q),
        .m     (m_q),
        .bits  (op_b[N-1:H]),
        .acc   (plain_acc)
    );

    bpm_mont_lane #(.N(N)) u_mont (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (lane_step),
        .trim  (lane_trim),
        .a     (a_q),
        .m     (m_q),
        .bits  (op_b[H-1:0]),
        .acc   (mont_acc)
    );

    bpm_mod_add #(.N(N)) u_merge (
        .x (plain_acc),
        .y (mont_acc),
        .m (m_q),
        .z (merged)
    );

    assign unused_merge_hi = ^merged[W-1:N];

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            product_q <= '0;
        end else begin
            done_q <= (state_q == S_MERGE);
            if (state_q == S_MERGE)
                product_q <= merged[N-1:0];
        end
    end

    assign ready   = (state_q == S_IDLE);
    assign done    = done_q;
    assign product = product_q;
endmodule

// File: rtl/bpm_checker.sv
module bpm_checker #(
    parameter int N = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ready,
    input logic              done,
    input logic [N-1:0]      product,
    input logic [N-1:0]      m_q,
    input bpm_pkg::state_t   state_q,
    input logic [N+1:0]      plain_acc,
    input logic [N+1:0]      mont_acc
);
    import bpm_pkg::*;

    p_result_reduced_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product < m_q));

    p_busy_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready);

    p_ready_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_no_done_at_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> (state_q == S_RUN && !done));

    p_plain_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN || state_q == S_TRIM) |-> (plain_acc < {2'b00, m_q}));

    p_mont_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN || state_q == S_TRIM) |-> (mont_acc < {1'b0, m_q, 1'b0}));

    p_product_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_MERGE) |=> $stable(product));
endmodule

bind bipartite_modmul bpm_checker #(.N(N)) u_bpm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ready     (ready),
    .done      (done),
    .product   (product),
    .m_q       (m_q),
    .state_q   (state_q),
    .plain_acc (plain_acc),
    .mont_acc  (mont_acc)
);

// File: tb/bipartite_modmul_test.sv
`timescale 1ns/1ps
module bipartite_modmul_test;
    localparam int N = 64;
    localparam int H = N / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] op_a = '0, op_b = '0, modulus = '0;
    logic         ready, done;
    logic [N-1:0] product;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    bipartite_modmul #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b), .modulus(modulus),
        .ready(ready), .done(done), .product(product)
    );

    task automatic check(input bit ok, input string req,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // A*B mod m, then divide by 2 modulo m H times
    function automatic logic [N-1:0] model(input logic [N-1:0] a,
                                           input logic [N-1:0] b,
                                           input logic [N-1:0] m);
        logic [2*N-1:0] t;
        t = ({{N{1'b0}}, a} * {{N{1'b0}}, b}) % {{N{1'b0}}, m};
        for (int i = 0; i < H; i++) begin
            if (t[0]) t = t + {{N{1'b0}}, m};
            t = t >> 1;
        end
        return t[N-1:0];
    endfunction

    // one operation; disturb = issue a start and new operands while busy
    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                          input logic [N-1:0] m, input string req,
                          input bit disturb);
        int cyc;
        logic mid_ready;
        logic [N-1:0] exp;
        exp = model(a, b, m);
        @(negedge clk);
        while (!ready) @(negedge clk);
        op_a = a; op_b = b; modulus = m; start = 1'b1;
        cyc = 0;
        mid_ready = 1'b1;
        while (cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) start = 1'b0;
            if (cyc == 2) mid_ready = ready;
            if (disturb && cyc == 4) begin
                start = 1'b1; op_a = ~a; op_b = ~b; modulus = m ^ 64'h2;
            end
            if (disturb && cyc == 5) start = 1'b0;
            if (done) break;
        end
        check(done === 1'b1, "R3 done seen", {63'b0, done}, 64'd1);
        check(cyc == H + 3, "R3 latency", 64'(cyc), 64'(H + 3));
        check(mid_ready === 1'b0, "R2 ready low while busy", {63'b0, mid_ready}, 64'd0);
        check(ready === 1'b1, "R2 ready with done", {63'b0, ready}, 64'd1);
        check(product === exp, req, product, exp);
        check(product < m, "R1 product below m", product, m);
        @(negedge clk);
        check(done === 1'b0, "R3 single-cycle done", {63'b0, done}, 64'd0);
        if (disturb) begin
            int extra = 0;
            for (int k = 0; k < H + 6; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            check(extra == 0, "R4 busy start ignored", 64'(extra), 64'd0);
            check(product === exp, "R5 operands captured at start", product, exp);
        end
    endtask

    task automatic t_reset;
        check(ready === 1'b1, "R6 reset ready", {63'b0, ready}, 64'd1);
        check(done === 1'b0, "R6 reset done", {63'b0, done}, 64'd0);
        check(product === '0, "R6 reset product", product, '0);
    endtask

    task automatic t_edges;
        logic [N-1:0] m;
        m = 64'hC3A5_0F1E_9B27_6D45;
        run_op(64'd0, 64'h1234_5678_9ABC_DEF0 % m, m, "R8 A zero", 1'b0);
        run_op(64'h0FED_CBA9_8765_4321, 64'd0, m, "R8 B zero", 1'b0);
        run_op(64'd1, 64'd1, m, "R8 A=B=1", 1'b0);
        run_op(m - 1, m - 1, m, "R8 A=B=m-1", 1'b0);
        run_op(64'd1, m - 1, m, "R8 A=1 B=m-1", 1'b0);
        m = 64'hFFFF_FFFF_FFFF_FFFF;
        run_op(m - 1, m - 1, m, "R7 modulus 2^N-1", 1'b0);
        run_op(m - 2, 64'hFFFF_FFFF_0000_0001, m, "R7 large operands", 1'b0);
        run_op(64'd5, 64'd6, 64'd7, "R1 small modulus", 1'b0);
        run_op(64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF, m, "R1 low half only", 1'b0);
    endtask

    task automatic t_random;
        for (int i = 0; i < 24; i++) begin
            logic [N-1:0] m, a, b;
            m = {$urandom(), $urandom()} | 64'd1;
            if (i % 3 == 0) m[N-1] = 1'b1;
            a = {$urandom(), $urandom()} % m;
            b = {$urandom(), $urandom()} % m;
            run_op(a, b, m, "R1 random product", 1'b0);
        end
    endtask

    task automatic t_busy;
        run_op(64'h1357_9BDF_2468_ACE0, 64'h0F0F_F0F0_1234_4321,
               64'hF00D_BEEF_CAFE_F00D, "R1 disturbed product", 1'b1);
    endtask

    task automatic t_hold;
        logic [N-1:0] keep;
        keep = product;
        repeat (10) @(negedge clk);
        check(product === keep, "R9 product held while idle", product, keep);
        op_a = 64'd3; op_b = 64'd4; modulus = 64'd11; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (H / 2) @(negedge clk);
        check(product === keep, "R9 product held while busy", product, keep);
        repeat (H) @(negedge clk);
        check(product === model(64'd3, 64'd4, 64'd11), "R9 product after update",
              product, model(64'd3, 64'd4, 64'd11));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_edges();
        t_random();
        t_busy();
        t_hold();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule